// File: doc/BRIEF.md
# Speculative Cache-or-TCM Array Select Predictor

This block decides, for each access on one side of a level-one memory system, whether to read the cache array or the tightly coupled memory (TCM) array. Only one array is read per access, which saves power. The guess is the kind of array that the previous resolved access on the same side went to. The hit resolution arrives with the request as `reqTarget`. If the guess was wrong, the block replays the access at the correct array. It holds the requester off until the replay is done, and the whole access then takes three cycles.

Sequential accesses (for example the later beats of a burst) always read the predicted array, and they complete in one cycle. The instruction side and the data side each use their own instance, so each side keeps its own prediction state. The array contents and the hit logic are outside this block.

Top module: `tcm_sel_predictor`

## Requirements
- R1: After reset the prediction is the cache (`arraySel` = 0, with 1 meaning TCM and 0 meaning cache), and `ready` is high while no request is present.
- R2: A non-sequential request whose `reqTarget` matches the prediction completes in the cycle it is presented. In that cycle `ready` = 1, `arrayEn` = 1, `arraySel` is the prediction and `arrayAddr` = `reqAddr`.
- R3: A non-sequential request whose `reqTarget` differs from the prediction takes exactly three cycles. `ready` is low in the first two cycles and high in the third. `replayPulse` is high in the second cycle only.
- R4: In the replay cycle, `arraySel` equals the resolved target of the request and `arrayAddr` equals the request's original address.
- R5: A request with `reqSeq` = 1 completes in one cycle and reads the predicted array, whatever its `reqTarget` is. It leaves the prediction unchanged.
- R6: Each completed non-sequential request sets the prediction to its `reqTarget` for the next request.
- R7: While a replay is in progress, any change on `reqValid`, `reqAddr`, `reqSeq` or `reqTarget` is ignored. Selection, address and timing follow the stalled request only.
- R8: A stream of non-sequential requests that alternates between cache and TCM costs three cycles per request. A stream that stays on one array costs one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqAddr | input | ADDR_W | Access address |
| reqSeq | input | 1 | Access is sequential to the previous one |
| reqTarget | input | 1 | Resolved array of the access (1 = TCM, 0 = cache) |
| arraySel | output | 1 | Array being read (1 = TCM, 0 = cache) |
| arrayEn | output | 1 | Read strobe for the selected array |
| arrayAddr | output | ADDR_W | Address presented to the selected array |
| ready | output | 1 | Current access completes this cycle |
| replayPulse | output | 1 | Access is being repeated at the correct array |

## Verification
Several input patterns are applied, and each one separates a different case.

- **Alternating cache/TCM stream.** Every request mispredicts, so every request pays the three-cycle cost. This pattern shows that the prediction really follows the last target.
- **Stream on a single array.** Only the first request, the one that leaves the reset prediction, can pay the cost. This separates a last-target predictor from one that always replays.
- **Sequential requests with a mismatched target.** These show that the sequential flag both skips the penalty and leaves the prediction untouched.
- **Replays with scrambled inputs during the stall.** These show that the captured address and target drive the replay, not the live inputs.
- **Seeded random mix.** This exercises the interleaving of all of the above.

// File: rtl/tcm_sel_pkg.sv
package tcm_sel_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic capture;    // latch address and resolved target, move prediction
    logic useCapture; // drive the array address from the captured copy
  } selCtrl_t;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_STALL = 1'b1
  } selState_t;

endpackage

// File: rtl/tcm_sel_datapath.sv
module tcm_sel_datapath
  import tcm_sel_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  selCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqTarget,
  output logic              predTcm,
  output logic [ADDR_W-1:0] arrayAddr
);

  logic [ADDR_W-1:0] capAddr;

  // Prediction register: last resolved target on this side.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      predTcm <= 1'b0;
      capAddr <= '0;
    end else if (ctrl.capture) begin
      predTcm <= reqTarget;
      capAddr <= reqAddr;
    end
  end

  always_comb begin
    arrayAddr = ctrl.useCapture ? capAddr : reqAddr;
  end

  // The prediction may only move when the control asks for a capture.
  AST_PRED_MOVES_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(predTcm)); // R5

endmodule

// File: rtl/tcm_sel_control.sv
module tcm_sel_control
  import tcm_sel_pkg::*;
#(
  parameter int PENALTY = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqSeq,
  input  logic     reqTarget,
  input  logic     predTcm,
  output selCtrl_t ctrl,
  output logic     arrayEn,
  output logic     ready,
  output logic     replayPulse
);

  localparam int EXTRA = PENALTY - 1;
  localparam int CW    = $clog2(EXTRA + 1);
  localparam logic [CW-1:0] CNT_START = CW'(EXTRA);
  localparam logic [CW-1:0] CNT_LAST  = CW'(1);

  selState_t state;
  logic [CW-1:0] waitCnt;
  logic mispredict;

  always_comb begin
    mispredict = (state == ST_RUN) && reqValid && !reqSeq && (reqTarget != predTcm);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_RUN;
      waitCnt <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (mispredict) begin
            state   <= ST_STALL;
            waitCnt <= CNT_START;
          end
        end
        ST_STALL: begin
          waitCnt <= waitCnt - CW'(1);
          if (waitCnt == CNT_LAST) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    ctrl.capture    = mispredict;
    ctrl.useCapture = (state == ST_STALL);
    replayPulse     = (state == ST_STALL) && (waitCnt == CNT_START);
    ready           = (state == ST_RUN) ? !mispredict : (waitCnt == CNT_LAST);
    arrayEn         = ((state == ST_RUN) && reqValid) || replayPulse;
  end

  AST_MISS_THEN_REPLAY: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |=> replayPulse); // R3
  AST_REPLAY_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    replayPulse |-> !ready); // R3
  AST_SEQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && reqValid && reqSeq) |-> ready); // R5
  AST_NO_BACK_TO_BACK_REPLAY: assert property (@(posedge clk) disable iff (!rstN)
    replayPulse |=> !replayPulse); // R7

endmodule

// File: rtl/tcm_sel_predictor.sv
module tcm_sel_predictor
  import tcm_sel_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PENALTY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSeq,
  input  logic              reqTarget,
  output logic              arraySel,
  output logic              arrayEn,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic              ready,
  output logic              replayPulse
);

  selCtrl_t ctrl;
  logic predTcm;

  tcm_sel_control #(.PENALTY(PENALTY)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqSeq      (reqSeq),
    .reqTarget   (reqTarget),
    .predTcm     (predTcm),
    .ctrl        (ctrl),
    .arrayEn     (arrayEn),
    .ready       (ready),
    .replayPulse (replayPulse)
  );

  tcm_sel_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .reqAddr   (reqAddr),
    .reqTarget (reqTarget),
    .predTcm   (predTcm),
    .arrayAddr (arrayAddr)
  );

  assign arraySel = predTcm;

  AST_REPLAY_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqSeq && ready && arrayEn) |=> (arraySel == $past(reqTarget))); // R6
  AST_REPLAY_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    replayPulse |=> (arrayAddr == $past(arrayAddr) || ready)); // R4

endmodule

// File: tb/tcm_sel_predictor_test.sv
module tcm_sel_predictor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqSeq = 1'b0;
  logic        reqTarget = 1'b0;
  logic        arraySel, arrayEn, ready, replayPulse;
  logic [31:0] arrayAddr;

  int checks = 0;
  int errors = 0;
  logic modelPred = 1'b0;

  always #2.5 clk = ~clk;

  tcm_sel_predictor #(.ADDR_W(32), .PENALTY(3)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSeq(reqSeq), .reqTarget(reqTarget), .arraySel(arraySel),
    .arrayEn(arrayEn), .arrayAddr(arrayAddr), .ready(ready),
    .replayPulse(replayPulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCycles(input logic pred, input logic s, input logic t);
    return (!s && t != pred) ? 3 : 1;
  endfunction

  task automatic doAccess(input logic [31:0] a, input logic s, input logic t,
                          input bit garble, input string tag);
    int expCyc;
    int cyc;
    bit sawReplay;
    logic rSel;
    logic [31:0] rAddr;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSeq = s; reqTarget = t;
    expCyc = expCycles(modelPred, s, t);
    #1;
    check(arraySel == modelPred, {tag, " R2 first-cycle select"}, arraySel, modelPred);
    check(arrayAddr == a && arrayEn, {tag, " R2 first-cycle addr/en"}, arrayAddr, a);
    cyc = 1; sawReplay = 0; rSel = 1'b0; rAddr = '0;
    while (!ready && cyc < 10) begin
      @(negedge clk);
      if (garble) begin
        reqAddr = ~a; reqTarget = ~t; reqSeq = ~s; reqValid = 1'b0;
      end
      #1;
      cyc++;
      if (replayPulse) begin
        sawReplay = 1; rSel = arraySel; rAddr = arrayAddr;
      end
    end
    check(cyc == expCyc, {tag, " R3 R8 cycles per access"}, cyc, expCyc);
    check(sawReplay == (expCyc == 3), {tag, " R3 replay pulse"}, sawReplay, expCyc == 3);
    if (sawReplay) begin
      check(rSel == t, {tag, " R4 replay select"}, rSel, t);
      check(rAddr == a, {tag, garble ? " R7 replay addr" : " R4 replay addr"}, rAddr, a);
    end
    if (!s) modelPred = t; // R6
    @(negedge clk);
    reqValid = 1'b0; reqSeq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1a2b3c;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset state
    check(arraySel == 1'b0, "R1 reset predicts cache", arraySel, 0);
    check(ready == 1'b1, "R1 ready while idle", ready, 1);

    // R8: single-array stream on cache: one cycle each
    for (int i = 0; i < 6; i++) doAccess(32'h100 + 4 * i, 1'b0, 1'b0, 0, "cache-only R8");
    // R8: alternating stream, three cycles each
    for (int i = 0; i < 8; i++) doAccess(32'h200 + 4 * i, 1'b0, i[0] ? 1'b0 : 1'b1, 0, "alternate R8");
    // TCM-only stream: first access replays, rest single cycle (R6)
    for (int i = 0; i < 6; i++) doAccess(32'h300 + 4 * i, 1'b0, 1'b1, 0, "tcm-only R6");
    // R5: sequential with mismatched target: one cycle, prediction unchanged
    doAccess(32'h400, 1'b1, 1'b0, 0, "seq-mismatch R5");
    doAccess(32'h404, 1'b1, 1'b0, 0, "seq-mismatch R5");
    doAccess(32'h408, 1'b0, 1'b1, 0, "after-seq R5");
    // R7: scrambled inputs during replay
    doAccess(32'hdead_0000, 1'b0, 1'b0, 1, "garbled R7");
    doAccess(32'hbeef_0000, 1'b0, 1'b1, 1, "garbled R7");
    doAccess(32'h0000_0010, 1'b0, 1'b1, 1, "garbled-hit R7");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = $urandom;
      doAccess(a, ($urandom % 4) == 0, $urandom % 2, ($urandom % 3) == 0, "random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule